// File: doc/BRIEF.md
# Printhead Row Address Scan Sequencer

This block generates the row-select lines for two ink jet printheads of thirteen rows each. At any moment the selected rows go to one head only. A four-bit code picks one of the thirteen rows, or no row. The code comes from one of two places. The first is an internal scan counter that walks a fixed reflected code in either direction. The second is four external select inputs that drive the decoder directly.

When counter mode is on, the select inputs take on control meanings. Select bit 0 becomes the counter step clock, select bit 1 becomes an active-low counter clear, and select bit 2 sets the direction. The decoded rows go to head A or head B as a head-select input chooses. An active-low channel enable can blank both heads at once.

The step clock is slow: at most 1 MHz, against a fast system clock. All control inputs are therefore brought into the system clock domain through a synchronizer. The step clock is treated as data, and its rising edge is detected. The row outputs are registered, so they never glitch while the code or the head changes.

Top module: `row_scan_sequencer`

## Requirements
- R1: A synchronous active-low reset (rst_n low at a rising clk edge) clears the scan position to code 0000 and drives all row outputs of both heads low; channel enable reads as off while reset holds.
- R2: In counter mode (scan_mode=1) with sel_in[2]=1, each step moves the code C3..C0 forward through 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100, 1101, 1111, 1110, 1010, 1000, and from 1000 it wraps to 0000.
- R3: In counter mode with sel_in[2]=0, each step moves the code backward through the same fourteen-entry sequence, and from 0000 it wraps to 1000.
- R4: In counter mode, the counter steps exactly once for each low-to-high transition of sel_in[0]. A high level held for any number of clocks causes no further step.
- R5: In counter mode, sel_in[1]=0 forces the code to 0000 and overrides any step. Counting resumes from 0000 after sel_in[1] returns high.
- R6: With scan_mode=0, the decoder takes its code straight from sel_in[3:0], with sel_in[3] as the MSB. The counter keeps its position and ignores sel_in[0] edges.
- R7: Codes 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100, 1101, 1111, 1110, 1010 and 1000 select rows 1 to 13 in that order, where row n is bit n-1 of a row output. Codes 0000, 1001 and 1011 select no row. At most one row is ever active.
- R8: head_sel=0 routes the selected row to row_a and head_sel=1 routes it to row_b. The head that is not selected stays all zero.
- R9: chan_en_n=1 drives both row outputs to all zero. The counter keeps responding to its controls in the meantime.
- R10: Every input passes a two-stage synchronizer. A change on sel_in, head_sel or chan_en_n in direct mode reaches the row outputs on the third rising clk edge after it is applied. A rising edge on sel_in[0] in counter mode reaches them on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be much faster than the step clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_mode | input | 1 | 1 = internal scan counter drives the decoder; 0 = sel_in drives it |
| sel_in | input | 4 | Direct code, or {unused, direction, clear_n, step clock} in counter mode |
| head_sel | input | 1 | 0 = head A, 1 = head B |
| chan_en_n | input | 1 | Active-low enable for the row outputs |
| row_a | output | 13 | Row select lines of head A, active high, bit n-1 = row n |
| row_b | output | 13 | Row select lines of head B, active high, bit n-1 = row n |

## Verification
In direct mode, a new code, head or enable level applied before a rising edge appears at the row outputs after the third rising edge. A step-clock edge in counter mode first has to pass the edge detector and then update the position register, so it appears after the fourth. The bench keeps a behavioural model that ages the applied inputs by the same number of edges. It compares both row outputs against that model on every falling edge. The directed checks wait at least four edges after each stimulus and hold every step-clock level for four clocks. The latency checks sample one edge before the due cycle and again on it.

// File: rtl/rsq_pkg.sv
// Package rsq_pkg
// Shared constants, the scan-code function and the synchronized control
// bundle of the row scan sequencer. Assumes a 4-bit code and 13 rows.
package rsq_pkg;

    localparam int ROW_COUNT = 13;
    localparam int CODE_W    = 4;
    localparam int SEQ_LEN   = ROW_COUNT + 1;
    localparam int IDX_W     = $clog2(SEQ_LEN);
    localparam int LAST_IDX  = SEQ_LEN - 1;

    // Control inputs after the synchronizer
    typedef struct packed {
        logic              chan_dis;   // high = both heads blanked
        logic              head_b;     // high = head B selected
        logic              cnt_mode;   // high = internal counter drives decoder
        logic [CODE_W-1:0] sel;        // direct code or counter controls
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Reset value: enable off, head A, direct mode, code zero
    localparam ctrl_t CTRL_IDLE = '{chan_dis: 1'b1, head_b: 1'b0,
                                    cnt_mode: 1'b0, sel: '0};

    // Code at a scan position: reflected binary up to the last row, whose
    // code is the MSB alone so that the wrap to zero changes one bit.
    function automatic logic [CODE_W-1:0] scan_code(input logic [IDX_W-1:0] idx);
        logic [CODE_W-1:0] c;
        if (int'(idx) == LAST_IDX)
            c = CODE_W'(1) << (CODE_W - 1);
        else
            c = CODE_W'(idx ^ (idx >> 1));
        return c;
    endfunction

endpackage

// File: rtl/rsq_input_sync.sv
// Module rsq_input_sync
// Multi-stage synchronizer for a bundle of slow asynchronous control
// inputs. Assumes each input holds longer than STAGES+1 clock periods.
module rsq_input_sync #(
    parameter int              WIDTH   = 7,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop stage captures the raw inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= d_in;
                end
            end else begin : g_next
                // Later stages settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/rsq_scan_counter.sv
// Module rsq_scan_counter
// Up/down scan counter over the fourteen-entry reflected code. It steps
// on a rising edge of the synchronized step level, and it is cleared by
// an active-low clear while in counter mode. Assumes synchronized inputs.
module rsq_scan_counter
    import rsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,     // counter mode active
    input  logic              step_lvl, // step clock level
    input  logic              clr_n,    // active-low counter clear
    input  logic              up,       // 1 = forward, 0 = backward
    output logic [CODE_W-1:0] code
);

    logic [IDX_W-1:0] pos_q;
    logic             step_prev_q;
    logic             step_rise;
    logic [IDX_W-1:0] pos_fwd;
    logic [IDX_W-1:0] pos_bwd;

    // Rising edge of the step clock in the system clock domain
    assign step_rise = step_lvl & ~step_prev_q;

    // Neighbouring positions with wrap at both ends
    assign pos_fwd = (int'(pos_q) == LAST_IDX) ? '0 : pos_q + 1'b1;
    assign pos_bwd = (pos_q == '0) ? IDX_W'(LAST_IDX) : pos_q - 1'b1;

    // Remember the previous step level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) step_prev_q <= 1'b0;
        else        step_prev_q <= step_lvl;
    end

    // Position register: clear wins over step, direct mode holds
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (mode && !clr_n)
            pos_q <= '0;
        else if (mode && step_rise)
            pos_q <= up ? pos_fwd : pos_bwd;
    end

    assign code = scan_code(pos_q);

    // R2 R3: every non-clearing change of the code flips exactly one bit
    assert_gray_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!(mode && !clr_n)) && code != $past(code))
            |-> $countones(code ^ $past(code)) == 1);

    // R4: without a fresh rising edge the code does not move
    assert_no_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !(step_lvl && !step_prev_q)) |=> $stable(code));

    // R5: clear in counter mode yields code zero next cycle
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !clr_n) |=> code == '0);

    // R6: direct mode freezes the counter
    assert_hold_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> $stable(code));

endmodule

// File: rtl/rsq_row_decoder.sv
// Module rsq_row_decoder
// Combinational 4-to-13 decoder: row n is active when the code equals
// the code at scan position n; any other code leaves every row idle.
module rsq_row_decoder
    import rsq_pkg::*;
(
    input  logic [CODE_W-1:0]    code,
    output logic [ROW_COUNT-1:0] rows
);

    generate
        for (genvar r = 0; r < ROW_COUNT; r++) begin : g_row
            localparam logic [IDX_W-1:0] POS = IDX_W'(r + 1);
            // Row r+1 matches its own scan code
            assign rows[r] = (code == scan_code(POS));
        end
    endgenerate

endmodule

// File: rtl/rsq_head_steer.sv
// Module rsq_head_steer
// Registers the decoded rows onto head A or head B and blanks both when
// the channel is disabled. Assumes synchronized head and enable inputs.
module rsq_head_steer
    import rsq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ROW_COUNT-1:0] rows_in,
    input  logic                 head_b,
    input  logic                 chan_dis,
    output logic [ROW_COUNT-1:0] row_a,
    output logic [ROW_COUNT-1:0] row_b
);

    logic [ROW_COUNT-1:0] row_a_d;
    logic [ROW_COUNT-1:0] row_b_d;

    // Steer decoded rows to the selected head, blank when disabled
    always_comb begin
        row_a_d = '0;
        row_b_d = '0;
        if (!chan_dis) begin
            if (head_b) row_b_d = rows_in;
            else        row_a_d = rows_in;
        end
    end

    // Glitch-free registered row outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_a <= '0;
            row_b <= '0;
        end else begin
            row_a <= row_a_d;
            row_b <= row_b_d;
        end
    end

    // R7: never more than one row on either head
    assert_onehot_rows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_a) && $onehot0(row_b));

    // R8: the head that is not selected stays idle
    assert_head_a_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        head_b |=> row_a == '0);
    assert_head_b_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !head_b |=> row_b == '0);

    // R9: disabled channel blanks both heads
    assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chan_dis |=> (row_a == '0 && row_b == '0));

endmodule

// File: rtl/row_scan_sequencer.sv
// Module row_scan_sequencer
// Top of the printhead row scan sequencer: synchronizes the controls,
// runs the scan counter, picks counter or direct code, decodes it to one
// of thirteen rows and registers the rows onto the selected head.
// Assumes the step clock is far slower than clk.
module row_scan_sequencer
    import rsq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_mode,
    input  logic [CODE_W-1:0]    sel_in,
    input  logic                 head_sel,
    input  logic                 chan_en_n,
    output logic [ROW_COUNT-1:0] row_a,
    output logic [ROW_COUNT-1:0] row_b
);

    localparam int SEL_STEP = 0;
    localparam int SEL_CLRN = 1;
    localparam int SEL_UP   = 2;

    ctrl_t                ctrl_raw;
    ctrl_t                ctrl_s;
    logic [CTRL_W-1:0]    ctrl_s_vec;
    logic [CODE_W-1:0]    cnt_code;
    logic [CODE_W-1:0]    dec_code;
    logic [ROW_COUNT-1:0] dec_rows;

    // Bundle raw inputs
    assign ctrl_raw = '{chan_dis: chan_en_n, head_b: head_sel,
                        cnt_mode: scan_mode, sel: sel_in};

    rsq_input_sync #(
        .WIDTH   (CTRL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTRL_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (ctrl_raw),
        .d_out (ctrl_s_vec)
    );

    assign ctrl_s = ctrl_t'(ctrl_s_vec);

    rsq_scan_counter u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (ctrl_s.cnt_mode),
        .step_lvl (ctrl_s.sel[SEL_STEP]),
        .clr_n    (ctrl_s.sel[SEL_CLRN]),
        .up       (ctrl_s.sel[SEL_UP]),
        .code     (cnt_code)
    );

    // Decoder source: counter in counter mode, select inputs otherwise
    assign dec_code = ctrl_s.cnt_mode ? cnt_code : ctrl_s.sel;

    rsq_row_decoder u_decoder (
        .code (dec_code),
        .rows (dec_rows)
    );

    rsq_head_steer u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rows_in  (dec_rows),
        .head_b   (ctrl_s.head_b),
        .chan_dis (ctrl_s.chan_dis),
        .row_a    (row_a),
        .row_b    (row_b)
    );

    // R1: one clock into reset both heads are idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(!rst_n) && !rst_n |-> (row_a == '0 && row_b == '0));

endmodule

// File: tb/row_scan_sequencer_tb.sv
module row_scan_sequencer_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    // vec = {chan_en_n, head_sel, scan_mode, sel_in[3:0]}
    logic [6:0]  vec = 7'b1000000;
    logic [12:0] row_a;
    logic [12:0] row_b;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    // Scan sequence from R2, positions 0..13
    logic [3:0] seq_tab [0:13] = '{4'b0000, 4'b0001, 4'b0011, 4'b0010,
                                   4'b0110, 4'b0111, 4'b0101, 4'b0100,
                                   4'b1100, 4'b1101, 4'b1111, 4'b1110,
                                   4'b1010, 4'b1000};

    always #10 clk = ~clk;

    row_scan_sequencer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_mode (vec[4]),
        .sel_in    (vec[3:0]),
        .head_sel  (vec[5]),
        .chan_en_n (vec[6]),
        .row_a     (row_a),
        .row_b     (row_b)
    );

    // Row vector for a code per R7
    function automatic logic [12:0] rows_of(input logic [3:0] c);
        for (int i = 1; i < 14; i++)
            if (seq_tab[i] == c) return 13'(1) << (i - 1);
        return '0;
    endfunction

    // Behavioural reference model, ages inputs by the R10 latencies
    logic [6:0]  h1, h2, h3;
    int          mpos;
    logic [12:0] ma, mb;
    always @(posedge clk) begin
        logic [12:0] r;
        logic [3:0]  c;
        if (!rst_n) begin
            h1 = 7'b1000000; h2 = 7'b1000000; h3 = 7'b1000000;
            mpos = 0; ma = '0; mb = '0;
        end else begin
            c = h2[4] ? seq_tab[mpos] : h2[3:0];
            r = rows_of(c);
            ma = (!h2[6] && !h2[5]) ? r : '0;
            mb = (!h2[6] &&  h2[5]) ? r : '0;
            if (h2[4]) begin
                if (!h2[1]) mpos = 0;
                else if (h2[0] && !h3[0])
                    mpos = h2[2] ? (mpos + 1) % 14 : (mpos + 13) % 14;
            end
            h3 = h2; h2 = h1; h1 = vec;
        end
        started = 1'b1;
    end

    // Per-clock comparison against the model (R10)
    always @(negedge clk) begin
        if (started && !done) begin
            n_vec++;
            if (row_a !== ma || row_b !== mb) begin
                n_bad++;
                $display("FAIL R10 model t=%0t a=%h b=%h expected a=%h b=%h",
                         $time, row_a, row_b, ma, mb);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [12:0] ea, input logic [12:0] eb);
        n_vec++;
        if (row_a !== ea || row_b !== eb) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h expected a=%h b=%h", tag, row_a, row_b, ea, eb);
        end
    endtask

    task automatic check_one(input string tag, input logic [12:0] v);
        n_vec++;
        if ($countones(v) != 1) begin
            n_bad++;
            $display("FAIL %s active rows=%0d expected 1", tag, $countones(v));
        end
    endtask

    task automatic pulse();
        vec[0] = 1'b1; tick(4);
        vec[0] = 1'b0; tick(4);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(4);
        check("R1 reset idle", '0, '0);
        // counter mode, head A, enabled, up, clear released
        vec = 7'b0010110;
        tick(4);
        check("R1 counter at 0000", '0, '0);

        // R2 full up cycle
        for (int i = 1; i <= 14; i++) begin
            pulse();
            check("R2 up step", rows_of(seq_tab[i % 14]), '0);
            if (i % 14 != 0) check_one("R7 one row up", row_a);
        end

        // R3 full down cycle on head B (R8)
        vec[5] = 1'b1; vec[2] = 1'b0;
        tick(4);
        check("R8 head B idle", '0, '0);
        for (int i = 1; i <= 14; i++) begin
            pulse();
            check("R3 down step", '0, rows_of(seq_tab[(14 - i) % 14]));
            if (i % 14 != 0) check_one("R7 one row down", row_b);
        end

        // R4: long high level steps once (count is at 0 now)
        vec[5] = 1'b0; vec[2] = 1'b1;
        vec[0] = 1'b1; tick(20);
        check("R4 single step on held level", rows_of(4'b0001), '0);
        vec[0] = 1'b0; tick(4);
        check("R4 no step on fall", rows_of(4'b0001), '0);

        // R5: clear
        pulse(); pulse(); pulse();
        check("R5 pre-clear row4", rows_of(4'b0110), '0);
        vec[1] = 1'b0; tick(4);
        check("R5 clear to 0000", '0, '0);
        pulse();
        check("R5 clear overrides step", '0, '0);
        vec[1] = 1'b1; tick(4);
        pulse();
        check("R5 resume from 0000", rows_of(4'b0001), '0);

        // R6: direct mode decode of all codes, counter held at row5
        pulse(); pulse(); pulse(); pulse();
        check("R6 counter at row5", rows_of(4'b0111), '0);
        vec[4] = 1'b0;
        for (int c = 0; c < 16; c++) begin
            vec[3:0] = 4'(c);
            tick(4);
            check("R6 R7 direct decode", rows_of(4'(c)), '0);
        end
        vec = 7'b0010110;
        tick(4);
        check("R6 counter held", rows_of(4'b0111), '0);

        // R9: disable blanks, counter keeps running
        vec[6] = 1'b1; tick(4);
        check("R9 disabled", '0, '0);
        pulse();
        check("R9 disabled while stepping", '0, '0);
        vec[6] = 1'b0; tick(4);
        check("R9 re-enabled row6", rows_of(4'b0101), '0);
        vec[5] = 1'b1; tick(4);
        check("R8 routed to B", '0, rows_of(4'b0101));

        // R10 latency: direct path 3 edges
        vec = 7'b0000000; tick(4);
        check("R10 direct idle", '0, '0);
        vec[3:0] = 4'b0001;
        tick(2);
        check("R10 direct before due", '0, '0);
        tick(1);
        check("R10 direct on due", rows_of(4'b0001), '0);
        // R10 latency: counter path 4 edges (counter still at row6)
        vec = 7'b0010110; tick(4);
        check("R10 counter row6", rows_of(4'b0101), '0);
        vec[0] = 1'b1;
        tick(3);
        check("R10 step before due", rows_of(4'b0101), '0);
        tick(1);
        check("R10 step on due", rows_of(4'b0100), '0);
        vec[0] = 1'b0; tick(4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule